// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block sits between dispatch and the architectural register file of an out-of-order core. Each instruction takes one slot of a circular buffer, in program order, when it dispatches. The slot number is handed back as the tag under which the execution units later report the instruction's result. Results may arrive in any order. They are kept in the slot and reach the register file only when their slot becomes the oldest one and retires.

Each slot keeps five things: the destination register, a flag saying whether the instruction writes a register, the program counter, the result word, and the completion status (done, exception, mispredict). The oldest slot is judged on every cycle. A completed normal entry retires and drives a register write. A completed mispredicted branch empties the buffer and redirects fetch to the target carried in its result word. A completed excepting entry empties the buffer without writing, redirects fetch to a fixed handler address and latches its own PC. Because exceptions act only at the oldest slot, they are precise.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `count_o` is 0, `disp_ready_o` is 1, `disp_idx_o` is 0, `commit_we_o` and `flush_o` are 0 and `epc_o` is 0.
- R2: A dispatch is taken when `disp_valid_i` and `disp_ready_o` are both high. The tag returned is the current `disp_idx_o`. The next tag is one higher, wrapping from DEPTH-1 to 0, and `count_o` rises by one.
- R3: When `count_o` equals DEPTH, `disp_ready_o` is 0 and a dispatch request changes nothing.
- R4: A write-back through `wb_valid_i` records data, exception and mispredict status in the slot named by `wb_idx_i`, and nothing appears on the retirement outputs while that slot is not the oldest.
- R5: Retirement is strictly in order. While the oldest slot has not completed, nothing retires, even if every younger slot has completed.
- R6: A completed oldest slot with neither exception nor mispredict retires in that cycle. If it writes a register, `commit_we_o` is 1 with its `commit_dst_o` and `commit_data_o`. At most one slot retires per cycle and `count_o` drops by one.
- R7: A completed oldest slot with the mispredict flag raises `flush_o` with `redirect_pc_o` equal to its result word, and `commit_we_o` stays 0.
- R8: A completed oldest slot with the exception flag raises `flush_o` with `redirect_pc_o` equal to HANDLER_PC and `commit_we_o` at 0. On the next cycle `epc_o` holds that slot's PC.
- R9: In the cycle after a flush, `count_o` is 0 and `disp_idx_o` equals the index of the slot that caused the flush. During the flush cycle `disp_ready_o` is 0 and a dispatch request is dropped.
- R10: A slot dispatched with `disp_wr_i` at 0 retires with `commit_we_o` at 0 and still frees its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_dst_i | input | AREG_W | Destination architectural register |
| disp_wr_i | input | 1 | Instruction writes a register |
| disp_pc_i | input | PC_W | Instruction PC |
| disp_ready_o | output | 1 | A slot is free and no flush is in progress |
| disp_idx_o | output | IDX_W | Tag given to the next dispatch |
| wb_valid_i | input | 1 | Completion report |
| wb_idx_i | input | IDX_W | Tag of the completing slot |
| wb_data_i | input | DATA_W | Result, or branch target on a mispredict |
| wb_exc_i | input | 1 | Instruction raised an exception |
| wb_mis_i | input | 1 | Branch was mispredicted |
| commit_we_o | output | 1 | Register file write enable |
| commit_dst_o | output | AREG_W | Register file write address |
| commit_data_o | output | DATA_W | Register file write data |
| flush_o | output | 1 | Discard all slots and redirect fetch |
| redirect_pc_o | output | PC_W | Fetch target while flush_o is high |
| epc_o | output | PC_W | PC of the last excepting instruction |
| count_o | output | CNT_W | Occupied slots |

## Verification
The checker watches the properties that hold on every cycle. The occupancy never exceeds DEPTH, a full buffer refuses dispatch, an accepted dispatch moves the tag by one with wrap, a retirement with a write lowers the count, a write never coincides with a flush, and the count is zero after a flush. Retirement order, the link between a tag and the result that later retires from it, the values of the redirect target and of the exception PC, and the position the tag returns to after a flush can only be shown by the bench. It does this by sweeping every fill level from one to DEPTH at moving pointer positions, with completions reported in reverse order.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    RET_IDLE,
    RET_COMMIT,
    RET_REDIRECT,
    RET_TRAP
  } ret_kind_e;
endpackage

// File: rtl/rob_ptr.sv
module rob_ptr #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_o  <= '0;
      tail_o  <= '0;
      count_o <= '0;
    end else if (flush_i) begin
      tail_o  <= head_o;
      count_o <= '0;
    end else begin
      if (push_i) tail_o <= step(tail_o);
      if (pop_i)  head_o <= step(head_o);
      count_o <= count_o + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign full_o = (count_o == CNT_W'(DEPTH));
endmodule

// File: rtl/rob_slots.sv
module rob_slots #(
  parameter int DEPTH  = 8,
  parameter int AREG_W = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  input  logic [AREG_W-1:0] alloc_dst_i,
  input  logic              alloc_wr_i,
  input  logic [PC_W-1:0]   alloc_pc_i,
  input  logic              wb_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic              wb_exc_i,
  input  logic              wb_mis_i,
  input  logic              free_i,
  input  logic [IDX_W-1:0]  free_idx_i,
  input  logic              clear_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic              rd_done_o,
  output logic              rd_exc_o,
  output logic              rd_mis_o,
  output logic              rd_wr_o,
  output logic [AREG_W-1:0] rd_dst_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [PC_W-1:0]   rd_pc_o
);
  logic [DEPTH-1:0]  valid_q, done_q, exc_q, mis_q, wr_q;
  logic [AREG_W-1:0] dst_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PC_W-1:0]   pc_q   [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit_alloc, hit_wb, hit_free;
    assign hit_alloc = alloc_i && (alloc_idx_i == IDX_W'(g));
    assign hit_wb    = wb_i && valid_q[g] && (wb_idx_i == IDX_W'(g));
    assign hit_free  = free_i && (free_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        done_q[g]  <= 1'b0;
        exc_q[g]   <= 1'b0;
        mis_q[g]   <= 1'b0;
        wr_q[g]    <= 1'b0;
        dst_q[g]   <= '0;
        data_q[g]  <= '0;
        pc_q[g]    <= '0;
      end else if (clear_i) begin
        valid_q[g] <= 1'b0;
        done_q[g]  <= 1'b0;
      end else if (hit_alloc) begin
        valid_q[g] <= 1'b1;
        done_q[g]  <= 1'b0;
        exc_q[g]   <= 1'b0;
        mis_q[g]   <= 1'b0;
        wr_q[g]    <= alloc_wr_i;
        dst_q[g]   <= alloc_dst_i;
        pc_q[g]    <= alloc_pc_i;
      end else if (hit_free) begin
        valid_q[g] <= 1'b0;
        done_q[g]  <= 1'b0;
      end else if (hit_wb) begin
        done_q[g]  <= 1'b1;
        exc_q[g]   <= wb_exc_i;
        mis_q[g]   <= wb_mis_i;
        data_q[g]  <= wb_data_i;
      end
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_done_o  = done_q[rd_idx_i];
  assign rd_exc_o   = exc_q[rd_idx_i];
  assign rd_mis_o   = mis_q[rd_idx_i];
  assign rd_wr_o    = wr_q[rd_idx_i];
  assign rd_dst_o   = dst_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];
  assign rd_pc_o    = pc_q[rd_idx_i];
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              head_valid_i,
  input  logic              head_done_i,
  input  logic              head_exc_i,
  input  logic              head_mis_i,
  input  logic              head_wr_i,
  input  logic [DATA_W-1:0] head_data_i,
  input  logic [PC_W-1:0]   head_pc_i,
  output logic              pop_o,
  output logic              flush_o,
  output logic              reg_we_o,
  output logic [PC_W-1:0]   redirect_pc_o,
  output logic [PC_W-1:0]   epc_o
);
  ret_kind_e kind;

  always_comb begin
    if (!(head_valid_i && head_done_i)) kind = RET_IDLE;
    else if (head_exc_i)                kind = RET_TRAP;
    else if (head_mis_i)                kind = RET_REDIRECT;
    else                                kind = RET_COMMIT;
  end

  assign pop_o         = (kind == RET_COMMIT);
  assign flush_o       = (kind == RET_TRAP) || (kind == RET_REDIRECT);
  assign reg_we_o      = pop_o && head_wr_i;
  assign redirect_pc_o = (kind == RET_TRAP) ? HANDLER_PC : PC_W'(head_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               epc_o <= '0;
    else if (kind == RET_TRAP) epc_o <= head_pc_i;
  end
endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH  = 8,
  parameter int AREG_W = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0800,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_valid_i,
  input  logic [AREG_W-1:0] disp_dst_i,
  input  logic              disp_wr_i,
  input  logic [PC_W-1:0]   disp_pc_i,
  output logic              disp_ready_o,
  output logic [IDX_W-1:0]  disp_idx_o,
  input  logic              wb_valid_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic              wb_exc_i,
  input  logic              wb_mis_i,
  output logic              commit_we_o,
  output logic [AREG_W-1:0] commit_dst_o,
  output logic [DATA_W-1:0] commit_data_o,
  output logic              flush_o,
  output logic [PC_W-1:0]   redirect_pc_o,
  output logic [PC_W-1:0]   epc_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [IDX_W-1:0] head, tail;
  logic full, push, pop;
  logic h_valid, h_done, h_exc, h_mis, h_wr;
  logic [PC_W-1:0] h_pc;

  assign disp_ready_o = !full && !flush_o;
  assign push         = disp_valid_i && disp_ready_o;
  assign disp_idx_o   = tail;

  rob_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .pop_i(pop), .flush_i(flush_o),
    .head_o(head), .tail_o(tail), .count_o(count_o), .full_o(full)
  );

  rob_slots #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W), .PC_W(PC_W)) u_slots (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .alloc_i(push), .alloc_idx_i(tail), .alloc_dst_i(disp_dst_i),
    .alloc_wr_i(disp_wr_i), .alloc_pc_i(disp_pc_i),
    .wb_i(wb_valid_i), .wb_idx_i(wb_idx_i), .wb_data_i(wb_data_i),
    .wb_exc_i(wb_exc_i), .wb_mis_i(wb_mis_i),
    .free_i(pop), .free_idx_i(head), .clear_i(flush_o), .rd_idx_i(head),
    .rd_valid_o(h_valid), .rd_done_o(h_done), .rd_exc_o(h_exc), .rd_mis_o(h_mis),
    .rd_wr_o(h_wr), .rd_dst_o(commit_dst_o), .rd_data_o(commit_data_o), .rd_pc_o(h_pc)
  );

  rob_retire #(.DATA_W(DATA_W), .PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_retire (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .head_valid_i(h_valid), .head_done_i(h_done), .head_exc_i(h_exc),
    .head_mis_i(h_mis), .head_wr_i(h_wr), .head_data_i(commit_data_o), .head_pc_i(h_pc),
    .pop_o(pop), .flush_o(flush_o), .reg_we_o(commit_we_o),
    .redirect_pc_o(redirect_pc_o), .epc_o(epc_o)
  );
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             disp_valid_i,
  input logic             disp_ready_o,
  input logic [IDX_W-1:0] disp_idx_o,
  input logic             commit_we_o,
  input logic             flush_o,
  input logic [CNT_W-1:0] count_o
);
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));

  p_full_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == CNT_W'(DEPTH)) |-> !disp_ready_o);

  p_tag_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && disp_ready_o) |=>
      disp_idx_o == (($past(disp_idx_o) == IDX_W'(DEPTH - 1)) ? IDX_W'(0)
                                                              : IDX_W'($past(disp_idx_o) + 1'b1)));

  p_commit_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_we_o && !(disp_valid_i && disp_ready_o)) |=> count_o == CNT_W'($past(count_o) - 1'b1));

  p_no_write_on_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !commit_we_o);

  p_flush_empties_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> count_o == '0);

  p_flush_stalls_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !disp_ready_o);
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .disp_valid_i(disp_valid_i),
  .disp_ready_o(disp_ready_o), .disp_idx_o(disp_idx_o),
  .commit_we_o(commit_we_o), .flush_o(flush_o), .count_o(count_o)
);

// File: tb/rob_core_test.sv
`timescale 1ns/1ps
module rob_core_test;
  localparam int DEPTH = 8;
  localparam logic [31:0] HPC = 32'h0000_0800;

  logic clk = 0, rst_ni = 0;
  logic disp_valid = 0, disp_wr = 0;
  logic [4:0] disp_dst = 0;
  logic [31:0] disp_pc = 0;
  logic disp_ready;
  logic [2:0] disp_idx;
  logic wb_valid = 0, wb_exc = 0, wb_mis = 0;
  logic [2:0] wb_idx = 0;
  logic [31:0] wb_data = 0;
  logic commit_we, flush;
  logic [4:0] commit_dst;
  logic [31:0] commit_data, redirect_pc, epc;
  logic [3:0] count;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rob_core uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .disp_valid_i(disp_valid), .disp_dst_i(disp_dst), .disp_wr_i(disp_wr), .disp_pc_i(disp_pc),
    .disp_ready_o(disp_ready), .disp_idx_o(disp_idx),
    .wb_valid_i(wb_valid), .wb_idx_i(wb_idx), .wb_data_i(wb_data), .wb_exc_i(wb_exc), .wb_mis_i(wb_mis),
    .commit_we_o(commit_we), .commit_dst_o(commit_dst), .commit_data_o(commit_data),
    .flush_o(flush), .redirect_pc_o(redirect_pc), .epc_o(epc), .count_o(count)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sample();
    @(negedge clk); #1;
  endtask

  task automatic dispatch(input logic [4:0] dst, input logic wr, input logic [31:0] pc,
                          output logic [2:0] idx);
    @(negedge clk);
    disp_valid = 1; disp_dst = dst; disp_wr = wr; disp_pc = pc;
    #1 idx = disp_idx;
    @(posedge clk); #0.5 disp_valid = 0;
  endtask

  task automatic wback(input logic [2:0] idx, input logic [31:0] d, input logic e, input logic m);
    @(negedge clk);
    wb_valid = 1; wb_idx = idx; wb_data = d; wb_exc = e; wb_mis = m;
    @(posedge clk); #0.5 wb_valid = 0; wb_exc = 0; wb_mis = 0;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int tail = 0;
    logic [2:0] idx;
    #5 rst_ni = 1;
    sample();
    chk("R1 count", 32'(count), 0);
    chk("R1 ready", 32'(disp_ready), 1);
    chk("R1 idx", 32'(disp_idx), 0);
    chk("R1 commit", 32'(commit_we), 0);
    chk("R1 flush", 32'(flush), 0);
    chk("R1 epc", epc, 0);

    // sweep every fill level, completions reported youngest first
    for (int n = 1; n <= DEPTH; n++) begin
      for (int i = 0; i < n; i++) begin
        dispatch(5'(i + 1), (i % 3) != 2, 32'h1000 + 32'(4 * i), idx);
        chk("R2 tag", 32'(idx), 32'((tail + i) % DEPTH));
      end
      sample();
      chk("R2 count", 32'(count), 32'(n));
      if (n == DEPTH) begin
        @(negedge clk); disp_valid = 1; #1;
        chk("R3 ready when full", 32'(disp_ready), 0);
        @(posedge clk); #0.5 disp_valid = 0;
        sample();
        chk("R3 count held", 32'(count), 32'(DEPTH));
      end
      for (int i = n - 1; i >= 1; i--) begin
        wback(3'((tail + i) % DEPTH), 32'(100 * n + i), 0, 0);
        sample();
        chk("R5 no commit before head", 32'(commit_we), 0);
        chk("R4 no flush", 32'(flush), 0);
      end
      wback(3'(tail % DEPTH), 32'(100 * n), 0, 0);
      for (int i = 0; i < n; i++) begin
        sample();
        chk("R6 count before pop", 32'(count), 32'(n - i));
        if ((i % 3) != 2) begin
          chk("R6 we", 32'(commit_we), 1);
          chk("R6 dst", 32'(commit_dst), 32'(i + 1));
          chk("R4 data", commit_data, 32'(100 * n + i));
        end else begin
          chk("R10 no write", 32'(commit_we), 0);
        end
      end
      sample();
      chk("R10 drained", 32'(count), 0);
      chk("R6 idle", 32'(commit_we), 0);
      tail = (tail + n) % DEPTH;
    end

    // mispredicted branch at second slot
    for (int i = 0; i < 4; i++) dispatch(5'(10 + i), 1, 32'h2000 + 32'(4 * i), idx);
    wback(3'((tail + 1) % DEPTH), 32'h0000_3000, 0, 1);
    wback(3'((tail + 2) % DEPTH), 32'h22, 0, 0);
    wback(3'((tail + 3) % DEPTH), 32'h33, 0, 0);
    wback(3'(tail), 32'h11, 0, 0);
    sample();
    chk("R6 older commits first", 32'(commit_we), 1);
    chk("R6 older data", commit_data, 32'h11);
    @(negedge clk); disp_valid = 1; #1;
    chk("R7 flush", 32'(flush), 1);
    chk("R7 redirect", redirect_pc, 32'h0000_3000);
    chk("R7 no write", 32'(commit_we), 0);
    chk("R9 ready low in flush", 32'(disp_ready), 0);
    @(posedge clk); #0.5 disp_valid = 0;
    sample();
    chk("R9 empty", 32'(count), 0);
    chk("R9 tag back", 32'(disp_idx), 32'((tail + 1) % DEPTH));
    chk("R9 flush gone", 32'(flush), 0);
    tail = (tail + 1) % DEPTH;

    // exception at second slot
    for (int i = 0; i < 3; i++) dispatch(5'(20 + i), 1, 32'h4000 + 32'(4 * i), idx);
    wback(3'((tail + 1) % DEPTH), 32'h55, 1, 0);
    wback(3'((tail + 2) % DEPTH), 32'h66, 0, 0);
    wback(3'(tail), 32'h44, 0, 0);
    sample();
    chk("R6 pre-trap commit", 32'(commit_we), 1);
    chk("R6 pre-trap dst", 32'(commit_dst), 20);
    sample();
    chk("R8 flush", 32'(flush), 1);
    chk("R8 handler", redirect_pc, HPC);
    chk("R8 no write", 32'(commit_we), 0);
    sample();
    chk("R8 epc", epc, 32'h4004);
    chk("R9 empty after trap", 32'(count), 0);
    chk("R9 tag after trap", 32'(disp_idx), 32'((tail + 1) % DEPTH));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule